// File: doc/BRIEF.md
# Shared Bus Arbiter with Instruction Broadcast Hand-off

This block decides which of several units drives a single shared 16-bit bus that carries instructions, addresses and data in turn. In the default configuration there are three units. Unit 0 is the fetch unit, which owns the bus whenever nobody else does. Unit 1 is the arithmetic extension unit and unit 2 is the I/O controller. A unit can take the bus explicitly by raising its request. The grant then ripples down a daisy chain that starts at the highest index, so the I/O controller wins over the arithmetic unit, and the arithmetic unit wins over the fetch unit. The owner keeps the bus for as long as it holds its request.

Ownership also moves implicitly. While the fetch unit owns the bus with nothing pending, it can broadcast a fetched instruction by pulsing `instr_valid`. In the next cycle every unit presents its decode result on `claim`. The claimant, chosen through the same chain order, takes the bus until it signals `done`, and control then returns to the fetch unit. When nobody claims the instruction, `illegal` pulses for one cycle and the fetch unit keeps the bus. The `bus_data` output carries the drive word of whichever unit currently owns the bus.

Top module: `shared_bus_arbiter`

## Requirements
- R1: During and right after a synchronous active-low reset, `owner` is 3'b001 (fetch unit), `grant` is 3'b000 and `illegal` is 0.
- R2: `owner` is one-hot in every cycle, and `bus_data` equals the 16-bit slice of `drv_data` belonging to the owning unit (unit k drives bits 16k+15..16k).
- R3: When the fetch unit owns the bus at rest and requests are sampled, the highest-indexed requester becomes `owner` one cycle later (bit 2 over bit 1 over bit 0), and `grant` equals `owner` for the whole transfer.
- R4: A granted owner keeps the bus while its own request stays high, whatever the other requests do. One cycle after it drops its request, ownership returns to the fetch unit and `grant` goes to 0. Any still-pending request is arbitrated again from there.
- R5: An `instr_valid` pulse at rest leaves the fetch unit as owner for one decode cycle. The `claim` sampled in that decode cycle hands the bus to the claimant one cycle later, and `grant` stays 0.
- R6: A claimant holds the bus until its own `done` bit is sampled high, and ownership then returns to the fetch unit on the next cycle. In the meantime, `done` bits of other units, requests, claims and `instr_valid` have no effect.
- R7: When several units claim the same instruction, the highest-indexed claimant takes the bus.
- R8: If `claim` is 3'b000 in the decode cycle, `illegal` is 1 for exactly one cycle and the fetch unit stays owner.
- R9: If a request and `instr_valid` are sampled together at rest, the request is granted and the broadcast is dropped, so no decode cycle follows.
- R10: `instr_valid` is ignored when the bus is not at rest (during a transfer). Claims presented after such a pulse change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 3 | Explicit bus request per unit |
| instr_valid | input | 1 | Fetch unit broadcasts an instruction this cycle |
| claim | input | 3 | Per-unit decode claim, sampled in the decode cycle |
| done | input | 3 | Per-unit end of a claimed instruction |
| drv_data | input | 48 | Concatenated 16-bit drive words, unit k at bits 16k+15..16k |
| grant | output | 3 | One-hot explicit grant, zero when the bus is held by a claim or at rest |
| owner | output | 3 | One-hot current bus owner |
| illegal | output | 1 | One-cycle pulse after an unclaimed broadcast |
| bus_data | output | 16 | Drive word of the current owner |

## Verification
A corrupted controller state appears at the ports within one cycle. A stuck decode state shows up as a missing hand-off or a spurious `illegal` pulse on the cycle after the claims are sampled. A lost hold shows up as `owner` changing while the owner's request or `done` is still pending. A broken chain link shows up at once as the wrong requester or claimant winning. A broken data gate shows up as `bus_data` mismatching the owner's drive word. The bench sweeps every request pattern and every claim pattern, and checks `owner`, `grant`, `illegal` and `bus_data` on each cycle where they must change or stay put.

// File: rtl/sba_pkg.sv
// sba_pkg: types and constants shared by the shared-bus arbiter modules.
// Assumes unit 0 is the fetch (home) unit and higher indices have higher priority.
package sba_pkg;

    // Controller phase of the bus.
    typedef enum logic [1:0] {
        ST_HOME   = 2'd0,  // fetch unit owns the bus, nothing pending
        ST_DECODE = 2'd1,  // broadcast instruction being decoded by all units
        ST_XFER   = 2'd2,  // explicit request/grant transfer in progress
        ST_EXEC   = 2'd3   // claimant executing a broadcast instruction
    } sba_state_e;

    // Index of the unit that owns the bus by default.
    localparam int HOME_UNIT = 0;

endpackage

// File: rtl/sba_chain_stage.sv
// sba_chain_stage: one link of a priority daisy chain.
// A stage that receives the chain token takes it when its unit asks,
// otherwise it passes the token on to the next (lower priority) link.
module sba_chain_stage (
    input  logic token_in,
    input  logic ask,
    output logic take,
    output logic token_out
);

    // Take or forward the token.
    assign take      = token_in & ask;
    assign token_out = token_in & ~ask;

endmodule

// File: rtl/sba_daisy_chain.sv
// sba_daisy_chain: N-link chain entered at the highest index.
// Produces the one-hot winner among the asking units and flags when
// the token fell off the end (no unit asked).
// Assumes the token is injected through chain_in every cycle it is used.
module sba_daisy_chain #(
    parameter int N = 3
) (
    input  logic         chain_in,
    input  logic [N-1:0] ask,
    output logic [N-1:0] win,
    output logic         chain_out
);

    logic [N:0] link;

    // Token enters at the top of the chain.
    assign link[N] = chain_in;

    for (genvar k = N - 1; k >= 0; k--) begin : g_stage
        sba_chain_stage u_stage (
            .token_in  (link[k+1]),
            .ask       (ask[k]),
            .take      (win[k]),
            .token_out (link[k])
        );
    end

    // Token left unused by every link.
    assign chain_out = link[0];

endmodule

// File: rtl/sba_bus_mux.sv
// sba_bus_mux: AND-OR selector that puts the owner's drive word on the bus.
// Assumes sel is one-hot; with zero or several bits set the words are OR-ed.
module sba_bus_mux #(
    parameter int N = 3,
    parameter int W = 16
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] drv,
    output logic [W-1:0]   bus
);

    logic [N*W-1:0] gated;

    for (genvar k = 0; k < N; k++) begin : g_gate
        assign gated[k*W +: W] = drv[k*W +: W] & {W{sel[k]}};
    end

    // OR together the gated words.
    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) begin
            bus = bus | gated[k*W +: W];
        end
    end

endmodule

// File: rtl/sba_ctrl.sv
// sba_ctrl: ownership controller of the shared bus.
// Tracks the bus phase, registers the one-hot owner and grant, and pulses
// the illegal flag after an unclaimed broadcast. Priority decisions come
// from the two daisy chains outside this module.
// Assumes req_win/claim_win are one-hot or zero and *_none mark "no asker".
module sba_ctrl
    import sba_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         instr_valid,
    input  logic [N-1:0] done,
    input  logic [N-1:0] req_win,
    input  logic         req_none,
    input  logic [N-1:0] claim_win,
    input  logic         claim_none,
    output logic [N-1:0] owner,
    output logic [N-1:0] grant,
    output logic         illegal
);

    localparam logic [N-1:0] HOME_OH = N'(1) << HOME_UNIT;
    localparam int           TOP     = N - 1;

    sba_state_e state;

    logic owner_asks;
    logic owner_done;

    // Owner still requesting / owner reporting completion.
    assign owner_asks = |(req & owner);
    assign owner_done = |(done & owner);

    // Phase, ownership and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HOME;
            owner   <= HOME_OH;
            grant   <= '0;
            illegal <= 1'b0;
        end else begin
            illegal <= 1'b0;
            case (state)
                ST_HOME: begin
                    if (!req_none) begin
                        state <= ST_XFER;
                        owner <= req_win;
                        grant <= req_win;
                    end else if (instr_valid) begin
                        state <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (!claim_none) begin
                        state <= ST_EXEC;
                        owner <= claim_win;
                    end else begin
                        state   <= ST_HOME;
                        illegal <= 1'b1;
                    end
                end
                ST_XFER: begin
                    if (!owner_asks) begin
                        state <= ST_HOME;
                        owner <= HOME_OH;
                        grant <= '0;
                    end
                end
                ST_EXEC: begin
                    if (owner_done) begin
                        state <= ST_HOME;
                        owner <= HOME_OH;
                    end
                end
                default: begin
                    state <= ST_HOME;
                    owner <= HOME_OH;
                    grant <= '0;
                end
            endcase
        end
    end

    // R2: exactly one owner at all times.
    p_owner_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(owner) == 1);

    // R3: any non-zero grant names the owner.
    p_grant_is_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (grant == owner));

    // R3: top-of-chain requester at rest always wins next cycle.
    p_top_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOME && req[TOP]) |=> owner[TOP]);

    // R4: no preemption while the owner keeps requesting.
    p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && owner_asks) |=> $stable(owner));

    // R6: claimant keeps the bus until its own done, without a grant.
    p_exec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !owner_done) |=> ($stable(owner) && grant == '0));

    // R8: illegal pulse only with the fetch unit owning the bus at rest.
    p_illegal_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (owner == HOME_OH && state == ST_HOME));

    // R9: a request at rest beats a simultaneous broadcast.
    p_req_beats_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOME && (|req) && instr_valid) |=> (state == ST_XFER));

endmodule

// File: rtl/shared_bus_arbiter.sv
// shared_bus_arbiter: top of the shared-bus arbiter.
// Combines a request daisy chain, a claim daisy chain, the ownership
// controller and the bus data selector. Unit 0 is the fetch unit; the
// chain is entered at unit N-1, which has the highest priority.
// Assumes all inputs are synchronous to clk.
module shared_bus_arbiter #(
    parameter int N_UNITS = 3,
    parameter int DATA_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_UNITS-1:0]          req,
    input  logic                        instr_valid,
    input  logic [N_UNITS-1:0]          claim,
    input  logic [N_UNITS-1:0]          done,
    input  logic [N_UNITS*DATA_W-1:0]   drv_data,
    output logic [N_UNITS-1:0]          grant,
    output logic [N_UNITS-1:0]          owner,
    output logic                        illegal,
    output logic [DATA_W-1:0]           bus_data
);

    logic [N_UNITS-1:0] req_win;
    logic               req_none;
    logic [N_UNITS-1:0] claim_win;
    logic               claim_none;

    // Request chain: picks the explicit requester.
    sba_daisy_chain #(.N(N_UNITS)) u_req_chain (
        .chain_in  (1'b1),
        .ask       (req),
        .win       (req_win),
        .chain_out (req_none)
    );

    // Claim chain: picks the unit taking a broadcast instruction.
    sba_daisy_chain #(.N(N_UNITS)) u_claim_chain (
        .chain_in  (1'b1),
        .ask       (claim),
        .win       (claim_win),
        .chain_out (claim_none)
    );

    sba_ctrl #(.N(N_UNITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .instr_valid (instr_valid),
        .done        (done),
        .req_win     (req_win),
        .req_none    (req_none),
        .claim_win   (claim_win),
        .claim_none  (claim_none),
        .owner       (owner),
        .grant       (grant),
        .illegal     (illegal)
    );

    sba_bus_mux #(.N(N_UNITS), .W(DATA_W)) u_mux (
        .sel (owner),
        .drv (drv_data),
        .bus (bus_data)
    );

endmodule

// File: tb/tb_shared_bus_arbiter.sv
// tb_shared_bus_arbiter: sweeps every request and claim pattern and checks
// owner, grant, illegal and bus_data against values computed here.
module tb_shared_bus_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  req;
    logic        instr_valid;
    logic [2:0]  claim;
    logic [2:0]  done;
    logic [47:0] drv_data;
    logic [2:0]  grant;
    logic [2:0]  owner;
    logic        illegal;
    logic [15:0] bus_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    shared_bus_arbiter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .instr_valid (instr_valid),
        .claim       (claim),
        .done        (done),
        .drv_data    (drv_data),
        .grant       (grant),
        .owner       (owner),
        .illegal     (illegal),
        .bus_data    (bus_data)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] top_bit(input logic [2:0] p);
        if (p[2])      return 3'b100;
        else if (p[1]) return 3'b010;
        else if (p[0]) return 3'b001;
        else           return 3'b000;
    endfunction

    function automatic logic [15:0] word_of(input logic [2:0] oh);
        if (oh == 3'b100)      return 16'h3333;
        else if (oh == 3'b010) return 16'h2222;
        else                   return 16'h1111;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Owner plus the data it must drive onto the bus.
    task automatic chk_owner(input string tag, input logic [2:0] exp);
        chk({tag, " owner"}, {29'd0, owner}, {29'd0, exp});
        chk({"R2 bus_data ", tag}, {16'd0, bus_data}, {16'd0, word_of(exp)});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] w;
        rst_n       = 1'b0;
        req         = '0;
        instr_valid = 1'b0;
        claim       = '0;
        done        = '0;
        drv_data    = {16'h3333, 16'h2222, 16'h1111};
        repeat (3) step();
        // R1: reset state
        chk_owner("R1 reset", 3'b001);
        chk("R1 grant", {29'd0, grant}, 32'd0);
        chk("R1 illegal", {31'd0, illegal}, 32'd0);
        rst_n = 1'b1;
        step();
        chk_owner("R1 after reset", 3'b001);

        // R3/R4: every request pattern
        for (int p = 1; p < 8; p++) begin
            req = 3'(p);
            step();
            w = top_bit(3'(p));
            chk_owner("R3 chain winner", w);
            chk("R3 grant", {29'd0, grant}, {29'd0, w});
            req = 3'b111;
            step();
            chk_owner("R4 no preemption", w);
            step();
            chk("R4 grant held", {29'd0, grant}, {29'd0, w});
            req = 3'b111 & ~w;
            step();
            chk_owner("R4 return home", 3'b001);
            chk("R4 grant cleared", {29'd0, grant}, 32'd0);
            step();
            chk_owner("R4 rearbitrate", top_bit(3'b111 & ~w));
            req = 3'b000;
            step();
            chk_owner("R4 home again", 3'b001);
        end

        // R5/R6/R7/R8: every claim pattern
        for (int c = 0; c < 8; c++) begin
            instr_valid = 1'b1;
            step();
            chk_owner("R5 decode cycle", 3'b001);
            instr_valid = 1'b0;
            claim = 3'(c);
            step();
            claim = 3'b000;
            if (c == 0) begin
                chk("R8 illegal pulse", {31'd0, illegal}, 32'd1);
                chk_owner("R8 fetch keeps bus", 3'b001);
                step();
                chk("R8 pulse one cycle", {31'd0, illegal}, 32'd0);
                chk_owner("R8 still home", 3'b001);
            end else begin
                w = top_bit(3'(c));
                chk_owner("R7 claimant", w);
                chk("R5 no grant", {29'd0, grant}, 32'd0);
                chk("R5 no illegal", {31'd0, illegal}, 32'd0);
                done = 3'b111 & ~w;
                req = 3'b111;
                claim = 3'b111;
                instr_valid = 1'b1;
                step();
                chk_owner("R6 hold until own done", w);
                step();
                chk_owner("R6 hold second cycle", w);
                done = w;
                req = 3'b000;
                claim = 3'b000;
                instr_valid = 1'b0;
                step();
                done = 3'b000;
                chk_owner("R6 back to fetch", 3'b001);
                step();
                chk_owner("R6 stays home", 3'b001);
            end
        end

        // R9: request together with broadcast
        req = 3'b010;
        instr_valid = 1'b1;
        step();
        instr_valid = 1'b0;
        chk_owner("R9 request wins", 3'b010);
        chk("R9 grant", {29'd0, grant}, 32'd2);
        req = 3'b000;
        step();
        chk_owner("R9 home", 3'b001);
        claim = 3'b100;
        step();
        claim = 3'b000;
        chk_owner("R9 broadcast dropped", 3'b001);
        chk("R9 no illegal", {31'd0, illegal}, 32'd0);
        step();
        chk_owner("R9 no late hand-off", 3'b001);

        // R10: broadcast during a transfer
        req = 3'b100;
        step();
        instr_valid = 1'b1;
        step();
        instr_valid = 1'b0;
        chk_owner("R10 transfer unaffected", 3'b100);
        req = 3'b000;
        step();
        chk_owner("R10 home", 3'b001);
        claim = 3'b010;
        step();
        claim = 3'b000;
        chk_owner("R10 claim ignored", 3'b001);
        chk("R10 no illegal", {31'd0, illegal}, 32'd0);
        step();
        chk_owner("R10 still home", 3'b001);
        chk("R10 illegal stays low", {31'd0, illegal}, 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule